// File: doc/BRIEF.md
# Per-Core Reset Command Register

This block is a 32-bit control register that keeps one reset bit for each of four processor cores, along with reset bits for neighbouring subsystems. Software writes the register as a whole word. The block does not drive the cores' reset lines from the stored levels. It compares the new value of each core bit with the value already stored and issues a one-cycle command only to the cores whose bit changes.

A bit that rises from 0 to 1 gives a hold-off command on that core's `coreOff` line. A bit that falls from 1 to 0 gives a power-on-and-release command on that core's `coreOnReset` line. A single write can command several cores, and can command them in different directions. The new value is stored after the comparison is made.

Some bit positions are reserved. They always read as zero and ignore writes. The power sequencing of the cores is handled downstream and is outside this block.

Top module: `cpu_reset_ctl`

## Requirements
- R1: After a hardware reset, `rdData` reads 0x00003D0F, so all four core bits (bits 0 to 3) are 1, and both command vectors are zero.
- R2: A write that changes core bit i from 0 to 1 sets `coreOff[i]` in the cycle after the write edge. No other core receives a command.
- R3: A write that changes core bit i from 1 to 0 sets `coreOnReset[i]` in the cycle after the write edge.
- R4: A write that leaves a core bit unchanged gives no command for that core. This holds even when the same value is written again.
- R5: One write can command several cores at once, mixing off and on-reset commands. A core never receives both commands in the same cycle.
- R6: The reserved bits, mask 0x0000C2F0, always read 0 and ignore written ones.
- R7: Every non-reserved bit stores the written value. The value is readable on `rdData` in the cycle after the write edge.
- R8: Each command pulse lasts exactly one cycle, including when writes come back to back.
- R9: When `wrEn` is low, the stored value does not change and no command is issued.
- R10: A hardware reset applied mid-operation reloads 0x00003D0F and issues no commands, either during the reset or in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| wrData | input | 32 | Data to write |
| rdData | output | 32 | Current register value |
| coreOff | output | 4 | One-cycle hold-off command, one bit per core |
| coreOnReset | output | 4 | One-cycle power-on-and-release command, one bit per core |

## Verification
The assertions assume that `wrEn` and `wrData` are settled before each rising edge. They also assume that `wrEn` is low at the time reset is released, so the first cycle after reset carries no command. The stimulus drives every input on the falling edge and holds `wrEn` low around each reset. A write to a core bit is the only event that may produce a command. The stimulus alternates writes with idle cycles and also issues writes back to back, so that both the single-cycle pulse width and the stability of the stored value are exercised.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  localparam int CORE_COUNT = 4;

  typedef logic [CORE_COUNT-1:0] coreVec_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic     load;     // store the masked write data
    coreVec_t offSet;   // cores commanded to hold off
    coreVec_t onSet;    // cores commanded on and released
  } rstStrobe_t;
endpackage

// File: rtl/cpu_rst_ctrl.sv
module cpu_rst_ctrl
  import cpu_rst_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int CORE_BASE = 0
) (
  input  logic                      wrEn,
  input  logic [REG_W-1:0]          wrDataMasked,
  input  coreVec_t                  oldCores,
  output rstStrobe_t                strobe
);
  localparam int CORE_TOP = CORE_BASE + CORE_COUNT - 1;

  coreVec_t newCores;
  coreVec_t diffCores;

  assign newCores  = wrDataMasked[CORE_TOP:CORE_BASE];
  assign diffCores = newCores ^ oldCores;

  assign strobe.load = wrEn;

  for (genvar i = 0; i < CORE_COUNT; i++) begin : g_core
    // A change in level gives a command; its direction picks which one
    assign strobe.offSet[i] = wrEn & diffCores[i] & newCores[i];
    assign strobe.onSet[i]  = wrEn & diffCores[i] & ~newCores[i];
  end
endmodule

// File: rtl/cpu_rst_datapath.sv
module cpu_rst_datapath
  import cpu_rst_pkg::*;
#(
  parameter int               REG_W     = 32,
  parameter int               CORE_BASE = 0,
  parameter logic [REG_W-1:0] RESET_VAL = 32'h0000_3D0F,
  parameter logic [REG_W-1:0] RSVD_MASK = 32'h0000_C2F0
) (
  input  logic             clk,
  input  logic             rstN,
  input  rstStrobe_t       strobe,
  input  logic [REG_W-1:0] wrDataMasked,
  output logic [REG_W-1:0] regQ,
  output coreVec_t         offQ,
  output coreVec_t         onQ
);
  localparam int CORE_TOP = CORE_BASE + CORE_COUNT - 1;
  localparam logic [REG_W-1:0] RESET_CLEAN = RESET_VAL & ~RSVD_MASK;

  coreVec_t coreField;
  assign coreField = regQ[CORE_TOP:CORE_BASE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= RESET_CLEAN;
      offQ <= '0;
      onQ  <= '0;
    end else begin
      offQ <= strobe.offSet;
      onQ  <= strobe.onSet;
      if (strobe.load) regQ <= wrDataMasked;
    end
  end

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regQ & RSVD_MASK) == '0);

  assert_off_sets_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (offQ != '0) |-> ((coreField & offQ) == offQ));

  assert_on_clears_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (onQ != '0) |-> ((coreField & onQ) == '0));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (offQ & onQ) == '0);

  assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((offQ | onQ) != '0) |=> (((offQ & $past(offQ)) | (onQ & $past(onQ))) == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(regQ) && offQ == '0 && onQ == '0));
endmodule

// File: rtl/cpu_reset_ctl.sv
module cpu_reset_ctl
  import cpu_rst_pkg::*;
#(
  parameter int               REG_W     = 32,
  parameter int               CORE_BASE = 0,
  parameter logic [REG_W-1:0] RESET_VAL = 32'h0000_3D0F,
  parameter logic [REG_W-1:0] RSVD_MASK = 32'h0000_C2F0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  output logic [CORE_COUNT-1:0] coreOff,
  output logic [CORE_COUNT-1:0] coreOnReset
);
  localparam int CORE_TOP = CORE_BASE + CORE_COUNT - 1;

  rstStrobe_t       strobe;
  logic [REG_W-1:0] wrDataMasked;
  logic [REG_W-1:0] regQ;
  coreVec_t         offQ;
  coreVec_t         onQ;

  assign wrDataMasked = wrData & ~RSVD_MASK;

  cpu_rst_ctrl #(.REG_W(REG_W), .CORE_BASE(CORE_BASE)) u_ctrl (
    .wrEn        (wrEn),
    .wrDataMasked(wrDataMasked),
    .oldCores    (regQ[CORE_TOP:CORE_BASE]),
    .strobe      (strobe)
  );

  cpu_rst_datapath #(
    .REG_W(REG_W), .CORE_BASE(CORE_BASE),
    .RESET_VAL(RESET_VAL), .RSVD_MASK(RSVD_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrDataMasked(wrDataMasked),
    .regQ        (regQ),
    .offQ        (offQ),
    .onQ         (onQ)
  );

  assign rdData      = regQ;
  assign coreOff     = offQ;
  assign coreOnReset = onQ;

  // R4: an unchanged core bit never leads to a command on the next cycle
  assert_no_cmd_unchanged_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && ((wrData[CORE_TOP:CORE_BASE] ^ rdData[CORE_TOP:CORE_BASE]) == '0)
    |=> (coreOff == '0 && coreOnReset == '0));

  // R7: the stored value follows the write, with reserved bits dropped
  assert_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & ~RSVD_MASK));
endmodule

// File: tb/cpu_reset_ctl_tb.sv
module cpu_reset_ctl_tb;
  localparam logic [31:0] RSVD  = 32'h0000_C2F0;
  localparam logic [31:0] RSTV  = 32'h0000_3D0F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  coreOff, coreOnReset;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mdl = RSTV;
  bit   monOn = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic [3:0]  off;
    logic [3:0]  on;
    string       req;
  } expItem_t;
  expItem_t q[$];

  always #10 clk = ~clk;   // 50 MHz

  cpu_reset_ctl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .coreOff(coreOff), .coreOnReset(coreOnReset)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: called on a falling edge; drives one cycle and queues the outcome
  task automatic cyc(bit w, logic [31:0] d, string req);
    expItem_t it;
    logic [31:0] nv;
    wrEn   = w;
    wrData = d;
    it.off = '0;
    it.on  = '0;
    if (w) begin
      nv     = d & ~RSVD;
      it.off = ~mdl[3:0] & nv[3:0];
      it.on  = mdl[3:0] & ~nv[3:0];
      mdl    = nv;
    end
    it.rd  = mdl;
    it.req = req;
    q.push_back(it);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Monitor: checks one queued item per cycle, a quarter period after the edge
  always @(posedge clk) begin
    if (monOn && q.size() > 0) begin
      expItem_t it;
      #5;
      it = q.pop_front();
      check(it.req, "rdData", rdData, it.rd);
      check(it.req, "coreOff", {28'h0, coreOff}, {28'h0, it.off});
      check(it.req, "coreOnReset", {28'h0, coreOnReset}, {28'h0, it.on});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rdData in reset", rdData, RSTV);
    check("R1", "cmds in reset", {24'h0, coreOff, coreOnReset}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "rdData after reset", rdData, RSTV);
    check("R1", "cmds after reset", {24'h0, coreOff, coreOnReset}, 32'h0);
    monOn = 1'b1;

    cyc(0, 32'hFFFF_FFFF, "R9");
    cyc(0, 32'h0, "R9");
    cyc(1, 32'h0000_3D0E, "R3");          // core0 1->0
    cyc(0, 32'h0, "R8");
    cyc(1, 32'h0000_3D0F, "R2");          // core0 0->1
    cyc(0, 32'h0, "R8");
    cyc(1, 32'h0000_3D0F, "R4");          // same value again
    cyc(0, 32'h0, "R4");
    cyc(1, 32'hFFFF_FFF0, "R5");          // all cores on-reset; reserved dropped
    cyc(0, 32'h0, "R6");
    cyc(1, 32'h0000_000A, "R5");          // cores 1 and 3 off
    cyc(1, 32'h0000_0005, "R5");          // mixed directions, back to back
    cyc(0, 32'h0, "R8");
    cyc(1, 32'h1234_C2F0, "R6");          // only reserved bits in low half
    cyc(1, 32'h8000_0001, "R7");
    cyc(1, 32'h8000_0000, "R8");          // off then on-reset on core0
    cyc(0, 32'h0, "R8");
    cyc(1, 32'h0000_0000, "R7");
    cyc(0, 32'h0, "R9");
    @(negedge clk);
    monOn = 1'b0;

    // R10: reset mid-operation
    wrEn = 1'b0;
    rstN = 1'b0;
    #5;
    check("R10", "rdData during reset", rdData, RSTV);
    check("R10", "cmds during reset", {24'h0, coreOff, coreOnReset}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "rdData after reset", rdData, RSTV);
    check("R10", "cmds after reset", {24'h0, coreOff, coreOnReset}, 32'h0);
    mdl = RSTV;
    monOn = 1'b1;
    cyc(1, 32'h0000_3D07, "R10");         // core3 on-reset from reloaded value
    cyc(0, 32'h0, "R8");
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule